// File: doc/BRIEF.md
# SDRAM Single-Beat Access Sequencer

This block turns a simple bus request (start address, direction, beat count and byte or word size) into a sequence of SDRAM commands. Each transfer opens its row with an activate command. Every data beat then gets its own read or write command with a fresh column address, so the SDRAM has to be programmed for a burst length of one. The transfer closes with a precharge. Issuing one command per beat lets several byte beats hit the same column of a word-wide device one after another.

A transfer may run across the end of a 512-byte row. When it does, the sequencer closes the current row, opens the next one and carries on, all inside the same transfer. Read data is captured after a run-time read latency of one to three cycles. Write data goes onto the bus in the same cycle as its write command, and a per-byte mask selects the addressed lane. Power-up initialisation, mode-register programming and refresh belong to other logic.

Top module: `sdr_beat_seq`

## Requirements
- R1: After reset the block deselects the device (`sd_cs_n` high, command pins all high), holds `req_ready` high, and keeps `rd_valid` and `done` low.
- R2: A request with a beat count of one or more is taken while `req_ready` is high. In the next cycle the block drives an activate command ({cs_n,ras_n,cas_n,we_n} = 0011), with row = address bits [ADDR_W-1:9] on `sd_addr`.
- R3: Each beat issues its own command in consecutive cycles: read = 0101, write = 0100. The column (address bits [8:1]) is on the low bits of `sd_addr` and `sd_addr[10]` is low.
- R4: Byte beats advance the address by one and word beats advance it by two. Two byte beats inside one word therefore reuse the same column.
- R5: A word-size request ignores bit 0 of its start address.
- R6: On a write beat `sd_dq_oe` and `wr_take` are high and `sd_dq_out` equals `wr_data`. `sd_dqm` bit i high masks data lane i (bits 8i+7:8i). A byte write masks the lane not named by address bit 0. Word writes and all reads drive a mask of 00, and the data bus is released on every command other than a write.
- R7: The cycle after the final beat carries a precharge (0010) with `sd_addr[10]` high. The cycle after that carries a one-cycle `done` pulse and the deselect command, and `req_ready` is high again.
- R8: If the next beat's address lies in a different 512-byte row, the block issues a precharge and then an activate of the new row, and then continues the beats with no `done` pulse.
- R9: Read data present on `sd_dq_in` at the clock edge that falls `rd_lat` edges after the read command edge is captured. It is presented on `rd_data`, with `rd_valid` high, in the following cycle. `rd_lat` of 1 to 3 selects the latency, and 0 acts as 1.
- R10: A request with a beat count of zero is ignored. No command is issued, no `done` is raised and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | High while idle and able to take a request |
| req_addr | input | ADDR_W | Byte start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word beats, 0 = byte beats |
| req_beats | input | CNT_W | Number of beats |
| wr_data | input | DATA_W | Write data for the current beat |
| wr_take | output | 1 | Current write beat consumes `wr_data` |
| rd_lat | input | LAT_W | Read latency in cycles |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle pulse after the final precharge |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | SA_W | Multiplexed row/column address |
| sd_dqm | output | DATA_W/8 | Byte mask, high masks a lane |
| sd_dq_out | output | DATA_W | Write data to the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Read data from the device |

## Verification
If the sequencer is in the wrong state, the port command changes in the very next cycle. A missed row crossing shows up as a read or write where a precharge/activate pair should be, and a lost beat count ends the transfer early or late, so the command scoreboard catches either on the first wrong command. A wrong lane mask or address step does not show on the command pins. It shows when the affected word is read back, because the bench memory model only applies unmasked lanes. A wrong latency tap makes `rd_valid` arrive one or more cycles away from its predicted cycle on the very first read beat.

// File: rtl/sdr_beat_pkg.sv
package sdr_beat_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACCESS = 2'd2,
      ST_PRECH  = 2'd3
   } seq_st_t;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_DESEL = 4'b1111,
      CMD_ACT   = 4'b0011,
      CMD_RD    = 4'b0101,
      CMD_WR    = 4'b0100,
      CMD_PRE   = 4'b0010
   } sd_cmd_t;

endpackage

// File: rtl/sdr_beat_ctl.sv
module sdr_beat_ctl
   import sdr_beat_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 8,
   parameter int LANE_W = 1,
   parameter int ROW_LG = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [CNT_W-1:0]  req_beats,
   output seq_st_t           st,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_write,
   output logic              cur_word,
   output logic              done
);

   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(1 << LANE_W);
   localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);

   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              row_change;
   logic              take;

   assign take       = req_valid && (req_beats != '0);
   assign addr_nxt   = cur_addr + (cur_word ? WORD_STEP : BYTE_STEP);
   assign row_change = addr_nxt[ADDR_W-1:ROW_LG] != cur_addr[ADDR_W-1:ROW_LG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_addr  <= '0;
         cur_write <= 1'b0;
         cur_word  <= 1'b0;
         left_q    <= '0;
         done      <= 1'b0;
      end else begin
         done <= (st == ST_PRECH) && (left_q == '0);
         unique case (st)
            ST_IDLE: begin
               if (take) begin
                  cur_addr  <= req_word ? {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}}
                                        : req_addr;
                  cur_write <= req_write;
                  cur_word  <= req_word;
                  left_q    <= req_beats;
                  st        <= ST_SETUP;
               end
            end
            ST_SETUP:  st <= ST_ACCESS;
            ST_ACCESS: begin
               cur_addr <= addr_nxt;
               left_q   <= left_q - 1'b1;
               if ((left_q == CNT_W'(1)) || row_change) st <= ST_PRECH;
            end
            ST_PRECH:  st <= (left_q == '0) ? ST_IDLE : ST_SETUP;
            default:   st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdr_beat_lane.sv
module sdr_beat_lane #(
   parameter int BYTES  = 2,
   parameter int LANE_W = 1
) (
   input  logic              en,
   input  logic              word,
   input  logic [LANE_W-1:0] lane,
   output logic [BYTES-1:0]  mask
);

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign mask[i] = en && !word && (lane != LANE_W'(i));
   end

endmodule

// File: rtl/sdr_beat_rdpipe.sv
module sdr_beat_rdpipe #(
   parameter int MAX_LAT = 3,
   parameter int DATA_W  = 16,
   parameter int LAT_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [LAT_W-1:0]  lat,
   input  logic [DATA_W-1:0] dq_in,
   output logic              vld,
   output logic [DATA_W-1:0] data
);

   logic [MAX_LAT-1:0] flags;
   logic               tap;

   if (MAX_LAT == 1) begin : g_one
      logic unused_lat;
      assign unused_lat = ^lat;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags <= '0;
         else        flags <= fire;
      end
      assign tap = flags[0];
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags <= '0;
         else        flags <= {flags[MAX_LAT-2:0], fire};
      end
      always_comb begin
         tap = flags[0];
         for (int k = 1; k < MAX_LAT; k++)
            if (int'(lat) == k + 1) tap = flags[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         data <= '0;
      end else begin
         vld <= tap;
         if (tap) data <= dq_in;
      end
   end

endmodule

// File: rtl/sdr_beat_seq.sv
module sdr_beat_seq
   import sdr_beat_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 8,
   parameter int ROW_LG  = 9,
   parameter int SA_W    = 13,
   parameter int AP_BIT  = 10,
   parameter int MAX_LAT = 3,
   localparam int BYTES  = DATA_W / 8,
   localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [CNT_W-1:0]  req_beats,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   input  logic [LAT_W-1:0]  rd_lat,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [SA_W-1:0]   sd_addr,
   output logic [BYTES-1:0]  sd_dqm,
   output logic [DATA_W-1:0] sd_dq_out,
   output logic              sd_dq_oe,
   input  logic [DATA_W-1:0] sd_dq_in
);

   localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam int ROW_W  = ADDR_W - ROW_LG;
   localparam int COL_W  = ROW_LG - LANE_W;

   if (DATA_W % 8 != 0 || BYTES < 2 || (1 << LANE_W) != BYTES) begin : g_bad_width
      $error("DATA_W must be a power-of-two count of bytes, two or more");
   end
   if (ROW_W < 1 || ROW_W > SA_W || COL_W > SA_W) begin : g_bad_addr
      $error("row or column does not fit the device address pins");
   end
   if (AP_BIT >= SA_W || AP_BIT < COL_W) begin : g_bad_ap
      $error("precharge-all bit must sit above the column inside sd_addr");
   end
   if (MAX_LAT < 1) begin : g_bad_lat
      $error("MAX_LAT must be at least one");
   end

   seq_st_t           st;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_write;
   logic              cur_word;
   logic              beat;
   logic              wbeat;
   logic [BYTES-1:0]  lane_mask;
   sd_cmd_t           cmd;

   sdr_beat_ctl #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .LANE_W (LANE_W),
      .ROW_LG (ROW_LG)
   ) ctl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_word  (req_word),
      .req_beats (req_beats),
      .st        (st),
      .cur_addr  (cur_addr),
      .cur_write (cur_write),
      .cur_word  (cur_word),
      .done      (done)
   );

   assign beat      = (st == ST_ACCESS);
   assign wbeat     = beat && cur_write;
   assign req_ready = (st == ST_IDLE);

   sdr_beat_lane #(
      .BYTES  (BYTES),
      .LANE_W (LANE_W)
   ) lane_i (
      .en   (wbeat),
      .word (cur_word),
      .lane (cur_addr[LANE_W-1:0]),
      .mask (lane_mask)
   );

   sdr_beat_rdpipe #(
      .MAX_LAT (MAX_LAT),
      .DATA_W  (DATA_W),
      .LAT_W   (LAT_W)
   ) rdp_i (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (beat && !cur_write),
      .lat   (rd_lat),
      .dq_in (sd_dq_in),
      .vld   (rd_valid),
      .data  (rd_data)
   );

   always_comb begin
      sd_addr = '0;
      unique case (st)
         ST_SETUP: begin
            cmd                = CMD_ACT;
            sd_addr[ROW_W-1:0] = cur_addr[ADDR_W-1:ROW_LG];
         end
         ST_ACCESS: begin
            cmd                = cur_write ? CMD_WR : CMD_RD;
            sd_addr[COL_W-1:0] = cur_addr[ROW_LG-1:LANE_W];
         end
         ST_PRECH: begin
            cmd             = CMD_PRE;
            sd_addr[AP_BIT] = 1'b1;
         end
         default: cmd = CMD_DESEL;
      endcase
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_dqm    = lane_mask;
   assign sd_dq_oe  = wbeat;
   assign wr_take   = wbeat;
   assign sd_dq_out = wr_data;

endmodule

// File: rtl/sdr_beat_chk.sv
module sdr_beat_chk #(
   parameter int LAT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sd_cs_n,
   input logic             sd_ras_n,
   input logic             sd_cas_n,
   input logic             sd_we_n,
   input logic             sd_dq_oe,
   input logic             wr_take,
   input logic             req_ready,
   input logic             rd_valid,
   input logic             done,
   input logic [LAT_W-1:0] rd_lat
);

   logic is_act, is_rd, is_wr, is_pre;
   assign is_act = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
   assign is_rd  = !sd_cs_n &&  sd_ras_n && !sd_cas_n &&  sd_we_n;
   assign is_wr  = !sd_cs_n &&  sd_ras_n && !sd_cas_n && !sd_we_n;
   assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;

   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> sd_cs_n); // R1
   AST_ACT_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |=> (is_rd || is_wr)); // R2
   AST_COL_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd || is_wr) |-> $past(is_act || is_rd || is_wr)); // R3
   AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_dq_oe || wr_take) |-> is_wr); // R6
   AST_PRE_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> $past(is_rd || is_wr)); // R7
   AST_DONE_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(is_pre) && sd_cs_n)); // R7
   AST_RD_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && int'(rd_lat) <= 1) |-> $past(is_rd, 2)); // R9
   AST_RD_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && int'(rd_lat) == 2) |-> $past(is_rd, 3)); // R9
   AST_RD_LAT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && int'(rd_lat) == 3) |-> $past(is_rd, 4)); // R9

endmodule

bind sdr_beat_seq sdr_beat_chk #(.LAT_W(LAT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_dq_oe  (sd_dq_oe),
   .wr_take   (wr_take),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .done      (done),
   .rd_lat    (rd_lat)
);

// File: tb/sdr_beat_seq_tb.sv
module sdr_beat_seq_tb_top;

   localparam int WD_CYCLES = 20000;
   localparam logic [3:0] C_DESEL = 4'b1111;
   localparam logic [3:0] C_ACT   = 4'b0011;
   localparam logic [3:0] C_RD    = 4'b0101;
   localparam logic [3:0] C_WR    = 4'b0100;
   localparam logic [3:0] C_PRE   = 4'b0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [7:0]  req_beats = '0;
   logic [15:0] wr_data = '0;
   logic        wr_take;
   logic [1:0]  rd_lat = 2'd1;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        done;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [12:0] sd_addr;
   logic [1:0]  sd_dqm;
   logic [15:0] sd_dq_out;
   logic        sd_dq_oe;
   logic [15:0] sd_dq_in = '0;

   always #10 clk = ~clk;

   sdr_beat_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
      .req_beats(req_beats), .wr_data(wr_data), .wr_take(wr_take),
      .rd_lat(rd_lat), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
      .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   typedef struct packed {
      logic [3:0]  cmd;
      logic [12:0] adr;
      logic [1:0]  dqm;
      logic [15:0] dat;
      logic        fin;
   } exp_t;

   exp_t        q_cmd[$];
   string       q_tag[$];
   logic [15:0] q_rd[$];
   int          q_lat[$];
   logic [15:0] wdq[$];
   logic [15:0] shadow[int];
   logic [15:0] model[int];
   logic [15:0] line_d[4];
   logic [10:0] open_row = '0;
   int checks = 0, fails = 0, cyc = 0, done_cnt = 0, cmd_cnt = 0, exp_done_cyc = -1;

   function automatic logic [15:0] seed_word(int k);
      return 16'(k * 40503) ^ 16'h5A5A;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // monitor, device model and scoreboard compare
   always @(negedge clk) begin
      logic [3:0]  c;
      logic [15:0] w;
      exp_t        e;
      string       t;
      int          k, eff;
      cyc++;
      if (cyc > WD_CYCLES) begin
         chk(0, "R1", "watchdog expired", cyc, WD_CYCLES);
         summary();
         $finish;
      end
      c   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      eff = (rd_lat == 2'd0) ? 1 : int'(rd_lat);
      sd_dq_in = line_d[0];
      for (int i = 0; i < 3; i++) line_d[i] = line_d[i+1];
      line_d[3] = '0;
      if (rst_n) begin
         if (c != C_DESEL) begin
            cmd_cnt++;
            if (q_cmd.size() == 0) begin
               chk(0, "R10", "unexpected command", int'(c), int'(C_DESEL));
            end else begin
               e = q_cmd.pop_front();
               t = q_tag.pop_front();
               chk(c == e.cmd, t, "command", int'(c), int'(e.cmd));
               chk(sd_addr == e.adr, t, "sd_addr", int'(sd_addr), int'(e.adr));
               if (e.cmd == C_WR) begin
                  chk(sd_dqm == e.dqm, "R6", "byte mask", int'(sd_dqm), int'(e.dqm));
                  chk(sd_dq_oe && wr_take && sd_dq_out == e.dat, "R6", "write data",
                      int'(sd_dq_out), int'(e.dat));
               end else begin
                  chk(!sd_dq_oe && !wr_take && sd_dqm == 2'b00, "R6", "bus released",
                      int'({sd_dq_oe, wr_take, sd_dqm}), 0);
               end
               if (e.cmd == C_PRE && e.fin) exp_done_cyc = cyc + 1;
            end
            if (c == C_ACT) open_row = sd_addr[10:0];
            if (c == C_RD) begin
               k = int'(open_row) * 256 + int'(sd_addr[7:0]);
               line_d[eff-1] = model.exists(k) ? model[k] : seed_word(k);
               q_lat.push_back(cyc + eff + 1);
            end
            if (c == C_WR) begin
               k = int'(open_row) * 256 + int'(sd_addr[7:0]);
               w = model.exists(k) ? model[k] : seed_word(k);
               if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
               if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
               model[k] = w;
               if (wdq.size() != 0) void'(wdq.pop_front());
            end
         end
         if (rd_valid) begin
            if (q_rd.size() == 0) chk(0, "R9", "unexpected rd_valid", 1, 0);
            else begin
               w = q_rd.pop_front();
               chk(rd_data == w, "R9", "read data", int'(rd_data), int'(w));
            end
            if (q_lat.size() == 0) chk(0, "R9", "rd_valid timing", cyc, -1);
            else begin
               k = q_lat.pop_front();
               chk(cyc == k, "R9", "rd_valid cycle", cyc, k);
            end
         end
         if (cyc == exp_done_cyc)
            chk(done && req_ready && sd_cs_n, "R7", "done pulse", int'(done), 1);
         else if (done)
            chk(0, "R7", "spurious done", 1, 0);
         if (done) done_cnt++;
      end
      wr_data = (wdq.size() != 0) ? wdq[0] : 16'h0;
   end

   task automatic push(logic [3:0] c, int adr, logic [1:0] m, logic [15:0] d, bit f, string t);
      exp_t e;
      e.cmd = c; e.adr = 13'(adr); e.dqm = m; e.dat = d; e.fin = f;
      q_cmd.push_back(e);
      q_tag.push_back(t);
   endtask

   // driver: builds the expected command stream from the requirements
   task automatic xfer(int addr, bit wr, int beats, bit word, int lat, string tag);
      int a, row, key, d0;
      logic [1:0]  m;
      logic [15:0] d, w;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      rd_lat = 2'(lat);
      a   = word ? (addr & ~1) : addr;
      row = a >> 9;
      if (beats > 0) push(C_ACT, row, 2'b00, 16'h0, 1'b0, "R2");
      for (int b = 0; b < beats; b++) begin
         key = a >> 1;
         w   = shadow.exists(key) ? shadow[key] : seed_word(key);
         if (wr) begin
            d = 16'(a * 7 + b * 257) ^ 16'hC3A5;
            m = word ? 2'b00 : ((a & 1) != 0 ? 2'b01 : 2'b10);
            push(C_WR, key & 255, m, d, 1'b0, tag);
            wdq.push_back(d);
            if (!m[0]) w[7:0]  = d[7:0];
            if (!m[1]) w[15:8] = d[15:8];
            shadow[key] = w;
         end else begin
            push(C_RD, key & 255, 2'b00, 16'h0, 1'b0, tag);
            q_rd.push_back(w);
         end
         a += word ? 2 : 1;
         if (b == beats - 1) push(C_PRE, 1024, 2'b00, 16'h0, 1'b1, "R7");
         else if ((a >> 9) != row) begin
            push(C_PRE, 1024, 2'b00, 16'h0, 1'b0, "R8");
            row = a >> 9;
            push(C_ACT, row, 2'b00, 16'h0, 1'b0, "R8");
         end
      end
      d0 = done_cnt;
      req_addr  = 20'(addr);
      req_write = wr;
      req_word  = word;
      req_beats = 8'(beats);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (beats > 0) while (done_cnt == d0) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   initial begin
      int n0, d0;
      for (int i = 0; i < 4; i++) line_d[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n, "R1", "deselect after reset",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 15);
      chk(req_ready && !rd_valid && !done, "R1", "idle outputs",
          int'({req_ready, rd_valid, done}), 4);

      xfer(20'h100, 1'b1, 4, 1'b1, 2, "R3");   // word writes
      xfer(20'h100, 1'b0, 4, 1'b1, 2, "R9");   // read back, latency 2
      xfer(20'h010, 1'b1, 2, 1'b0, 1, "R4");   // two bytes, one column
      xfer(20'h010, 1'b0, 2, 1'b0, 1, "R4");   // byte reads reuse the column
      xfer(20'h1FC, 1'b1, 3, 1'b1, 3, "R8");   // crosses into row 1
      xfer(20'h1FC, 1'b0, 3, 1'b1, 3, "R8");
      xfer(20'h021, 1'b0, 1, 1'b1, 0, "R5");   // odd word address, latency 0 acts as 1
      xfer(20'h031, 1'b1, 1, 1'b0, 2, "R6");   // upper-lane byte write
      xfer(20'h030, 1'b0, 1, 1'b1, 3, "R6");
      xfer(20'h3F0, 1'b1, 20, 1'b1, 1, "R8");
      xfer(20'h3F0, 1'b0, 20, 1'b1, 1, "R8");
      xfer(20'h5FE, 1'b0, 3, 1'b0, 2, "R4");   // byte reads across a row

      n0 = cmd_cnt;
      d0 = done_cnt;
      xfer(20'h200, 1'b1, 0, 1'b1, 1, "R10");
      chk(cmd_cnt == n0 && done_cnt == d0 && req_ready, "R10", "zero-beat request",
          cmd_cnt - n0, 0);

      chk(q_cmd.size() == 0 && q_rd.size() == 0 && q_lat.size() == 0, "R3",
          "scoreboard drained", q_cmd.size() + q_rd.size(), 0);
      summary();
      $finish;
   end

endmodule